// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit watches the synchronized input levels of a 95-pin GPIO bank and turns qualifying activity on each pin into a latched status bit. For every pin, a mode bit and a polarity bit pick one of four trigger kinds: rising edge, falling edge, low level or high level. Status bits are packed 32 pins to a word. Software clears them by writing ones to a status word. A separate enable bitmap, also packed 32 to a word, chooses which latched bits reach one combined interrupt line.

A pin only produces events when it is configured for GPIO use and its input sensing is switched on. Edge detection compares each pin's level with its level on the previous clock. A latched bit stays set until software clears it, whether or not the pin is enabled. Software can therefore inspect, or enable late, an event that arrived while the pin was masked.

Top module: `gpint_unit`

## Requirements
- R1: After reset every status bit and every enable bit reads 0, and irq_o is 0.
- R2: With mode 0 and polarity 0, a 0-to-1 change of a pin's level sets that pin's status bit on the first clock edge that samples the new level. A level that stays high adds no further event.
- R3: With mode 0 and polarity 1, a 1-to-0 change of the level sets the status bit on the first clock edge that samples the new level.
- R4: With mode 1 and polarity 0, the status bit sets on every clock while the level is 0. A clear issued while the level is still 0 leaves the bit set. Once the level is 1, a clear removes the bit.
- R5: With mode 1 and polarity 1, the status bit sets on every clock while the level is 1.
- R6: A write to byte address 0x80 + 4*w (w = 0..2) clears each status bit of word w (pins 32*w to 32*w+31) whose data bit is 1. Status bits whose data bit is 0 are untouched. Data 0xFFFFFFFF clears the whole word.
- R7: A write to 0x90 + 4*w loads enable word w from the data. Bit positions beyond pin 94 always read 0. Writes to any other address change no status or enable bit.
- R8: irq_o is 1 exactly when some pin has both its status bit and its enable bit set. Status bits latch events even while the pin's enable bit is 0.
- R9: When a clear and a new event hit the same status bit on the same clock, the bit stays set.
- R10: A pin whose use_gpio bit or sense_en bit is 0 never sets its status bit.
- R11: The first clock after reset release detects no edge, even if a pin was already at its active edge level during reset. Level events are not affected by this rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | 95 | Synchronized pin levels |
| trig_mode | input | 95 | Per-pin mode: 0 edge, 1 level |
| trig_inv | input | 95 | Per-pin polarity: edge 0 rising / 1 falling; level 0 low / 1 high |
| use_gpio | input | 95 | 1 when the pin is in GPIO use |
| sense_en | input | 95 | 1 when input sensing is on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| status_o | output | 96 | Packed status bitmap (bit 95 is always 0) |
| enable_o | output | 96 | Packed enable bitmap (bit 95 is always 0) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets four hazards:

- Timing of the first edge after reset. A design that primes its previous-level register wrongly reports a phantom rising edge on a pin that was high during reset.
- A clear that coincides with an active level or a new edge. A design that lets the clear win drops a real event.
- Partial clears, and writes to the highest word or to unused addresses. Such writes expose a design that clears whole words, sets the unused bit 95, or aliases an out-of-range address onto a real word.
- Pins that are not GPIO or not sensing, toggled in the same run. They reveal a design whose qualification gate is missing.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

  localparam int WORD_W = 32;

  // Number of packed status words needed for a bank.
  function automatic int words_for(input int npins);
    return (npins + WORD_W - 1) / WORD_W;
  endfunction

  // Mode/polarity decode for one pin: 0x edge, 1x level; low bit flips polarity.
  function automatic logic pin_event(input logic mode, input logic inv,
                                     input logic cur, input logic prev,
                                     input logic primed, input logic elig);
    logic edge_hit;
    logic lvl_hit;
    edge_hit = primed & (inv ? (prev & ~cur) : (cur & ~prev));
    lvl_hit  = (cur == inv);
    return elig & (mode ? lvl_hit : edge_hit);
  endfunction

  // Mask of valid pin positions inside word w of a bank.
  function automatic logic [WORD_W-1:0] word_mask(input int npins, input int w);
    int remain;
    remain = npins - w * WORD_W;
    if (remain >= WORD_W) return '1;
    if (remain <= 0) return '0;
    return WORD_W'((64'd1 << remain) - 64'd1);
  endfunction

endpackage

// File: rtl/gpint_pin.sv
module gpint_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic mode,
  input  logic inv,
  input  logic elig,
  input  logic primed,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign evt = gpint_pkg::pin_event(mode, inv, level, prev_q, primed, elig);
endmodule

// File: rtl/gpint_word.sv
module gpint_word #(
  parameter int W = gpint_pkg::WORD_W,
  parameter logic [W-1:0] VMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         pending
);
  logic [W-1:0] status_q, enable_q;
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      // a fresh event outranks a clear on the same bit
      status_q <= ((status_q & ~clr_mask) | evt) & VMASK;
      if (en_wr) enable_q <= wdata & VMASK;
    end
  end

  assign status  = status_q;
  assign enable  = enable_q;
  assign pending = |(status_q & enable_q);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask & ~evt)) == '0));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt & VMASK)) == $past(evt & VMASK)));

  assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));
endmodule

// File: rtl/gpint_unit.sv
module gpint_unit #(
  parameter int NPINS = 95,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] EN_BASE = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_level,
  input  logic [NPINS-1:0]  trig_mode,
  input  logic [NPINS-1:0]  trig_inv,
  input  logic [NPINS-1:0]  use_gpio,
  input  logic [NPINS-1:0]  sense_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [gpint_pkg::words_for(NPINS)*gpint_pkg::WORD_W-1:0] status_o,
  output logic [gpint_pkg::words_for(NPINS)*gpint_pkg::WORD_W-1:0] enable_o,
  output logic              irq_o
);
  localparam int W      = gpint_pkg::WORD_W;
  localparam int NWORDS = gpint_pkg::words_for(NPINS);
  localparam int FLAT   = NWORDS * W;

  logic              primed_q;
  logic [NPINS-1:0]  elig;
  logic [FLAT-1:0]   evt_flat;
  logic [NWORDS-1:0] clr_hit, en_hit, word_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  assign elig = use_gpio & sense_en;

  for (genvar p = 0; p < FLAT; p++) begin : g_pin
    if (p < NPINS) begin : g_real
      gpint_pin u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (pin_level[p]),
        .mode   (trig_mode[p]),
        .inv    (trig_inv[p]),
        .elig   (elig[p]),
        .primed (primed_q),
        .evt    (evt_flat[p])
      );
    end else begin : g_pad
      assign evt_flat[p] = 1'b0;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(STAT_BASE + ADDR_W'(4 * w));
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_BASE + ADDR_W'(4 * w));
    assign clr_hit[w] = wr_en && (wr_addr == A_ST);
    assign en_hit[w]  = wr_en && (wr_addr == A_EN);

    gpint_word #(.W(W), .VMASK(gpint_pkg::word_mask(NPINS, w))) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_flat[w*W +: W]),
      .clr_wr  (clr_hit[w]),
      .en_wr   (en_hit[w]),
      .wdata   (wr_data),
      .status  (status_o[w*W +: W]),
      .enable  (enable_o[w*W +: W]),
      .pending (word_pend[w])
    );
  end

  assign irq_o = |word_pend;

  assert_eligible_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o[NPINS-1:0] & ~$past(status_o[NPINS-1:0]) & ~$past(elig)) == '0));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o == '0) |-> !irq_o);

  assert_one_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_hit | en_hit));
endmodule

// File: tb/test_gpint_unit.sv
module test_gpint_unit;
  localparam int NP = 95;
  localparam int FL = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] lvl = '0, mde = '0, inv = '0, usg = '0, sen = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [FL-1:0] status_o, enable_o;
  logic irq_o;

  gpint_unit i_gpint_unit (
    .clk(clk), .rst_n(rst_n), .pin_level(lvl), .trig_mode(mde), .trig_inv(inv),
    .use_gpio(usg), .sense_en(sen), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int            target;
    string         tag;
    logic [FL-1:0] st;
    logic [FL-1:0] en;
    logic          irq;
  } item_t;
  item_t sbq[$];

  // reference state
  logic [FL-1:0] m_st = '0, m_en = '0;
  logic [NP-1:0] m_prev = '0;
  bit m_primed = 0;

  // monitor
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].target == cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (status_o !== it.st || enable_o !== it.en || irq_o !== it.irq) begin
        errors++;
        $display("FAIL %s: status=%h enable=%h irq=%b expected status=%h enable=%h irq=%b",
                 it.tag, status_o, enable_o, irq_o, it.st, it.en, it.irq);
      end
    end
  end

  // driver: applies one clock of stimulus and predicts the outcome
  task automatic step(input string tag, input logic we = 0,
                      input logic [7:0] a = 0, input logic [31:0] d = 0);
    logic [FL-1:0] clr, hit;
    item_t it;
    clr = '0;
    hit = '0;
    wr_en = we; wr_addr = a; wr_data = d;
    for (int p = 0; p < NP; p++) begin
      if (usg[p] && sen[p]) begin
        case ({mde[p], inv[p]})
          2'b00: hit[p] = m_primed && lvl[p] && !m_prev[p];
          2'b01: hit[p] = m_primed && !lvl[p] && m_prev[p];
          2'b10: hit[p] = !lvl[p];
          default: hit[p] = lvl[p];
        endcase
      end
    end
    if (we && a[1:0] == 2'b00 && a >= 8'h80 && a < 8'h8C) clr[((a - 8'h80) >> 2) * 32 +: 32] = d;
    m_st = (m_st & ~clr) | hit;
    if (we && a[1:0] == 2'b00 && a >= 8'h90 && a < 8'h9C) m_en[((a - 8'h90) >> 2) * 32 +: 32] = d;
    m_st[FL-1] = 1'b0;
    m_en[FL-1] = 1'b0;
    m_prev = lvl;
    m_primed = 1;
    it.target = cyc + 1; it.tag = tag; it.st = m_st; it.en = m_en; it.irq = |(m_st & m_en);
    sbq.push_back(it);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // pin setup during reset
    usg[0] = 1; sen[0] = 1;                                   // rising
    usg[1] = 1; sen[1] = 1; inv[1] = 1; lvl[1] = 1;           // falling
    usg[2] = 1; sen[2] = 1; mde[2] = 1; lvl[2] = 1;           // low level
    usg[3] = 1; sen[3] = 1; mde[3] = 1; inv[3] = 1;           // high level
    usg[5] = 1; sen[5] = 1; lvl[5] = 1;                       // rising, high in reset
    usg[94] = 1; sen[94] = 1;                                 // rising, top pin
    sen[40] = 1;                                              // not GPIO use
    usg[41] = 1;                                              // sensing off
    repeat (3) @(negedge clk);
    checks++;
    if (status_o !== '0 || enable_o !== '0 || irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: status=%h enable=%h irq=%b expected all 0", status_o, enable_o, irq_o);
    end
    rst_n = 1'b1;
    step("R1 R11 first clock, no edge");
    step("R11 steady high level, no edge");
    lvl[0] = 1; step("R2 rising edge sets bit 0");
    step("R2 high level holds, no new event");
    lvl[1] = 0; step("R3 falling edge sets bit 1");
    step("R8 latched while disabled, irq 0");
    step("R8 enable bit 1 raises irq", 1, 8'h90, 32'h2);
    step("R6 partial clear of bit 0", 1, 8'h80, 32'h1);
    step("R6 clear whole word", 1, 8'h80, 32'hFFFF_FFFF);
    lvl[2] = 0; step("R4 low level sets bit 2");
    step("R4 clear while low leaves bit set", 1, 8'h80, 32'h4);
    lvl[2] = 1; step("R4 level inactive, bit kept");
    step("R4 clear after inactive", 1, 8'h80, 32'h4);
    lvl[3] = 1; step("R5 high level sets bit 3");
    lvl[3] = 0; step("R5 level dropped");
    step("R5 clear", 1, 8'h80, 32'h8);
    lvl[0] = 0; step("R9 prep low");
    lvl[0] = 1; step("R9 prep edge");
    lvl[0] = 0; step("R9 prep low again");
    lvl[0] = 1; step("R9 edge with clear, event wins", 1, 8'h80, 32'h1);
    step("R9 plain clear", 1, 8'h80, 32'h1);
    lvl[40] = 1; lvl[41] = 1; step("R10 unqualified pins rise");
    lvl[40] = 0; step("R10 unqualified pins idle");
    step("R7 enable top word", 1, 8'h98, 32'hFFFF_FFFF);
    step("R7 out-of-range status address", 1, 8'h8C, 32'hFFFF_FFFF);
    step("R7 unused address", 1, 8'hA0, 32'hFFFF_FFFF);
    step("R7 misaligned address", 1, 8'h91, 32'h0);
    lvl[94] = 1; step("R7 R8 top pin raises irq");
    step("R6 clear top word", 1, 8'h88, 32'hFFFF_FFFF);
    step("R8 enable word 0 cleared", 1, 8'h90, 32'h0);
    repeat (2) @(negedge clk);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule